// File: doc/BRIEF.md
# Debug Freeze and Exception Capture Control

This block decides when a processor core is frozen on behalf of a debugger. A debug-side control register carries two bits, a hold bit that requests a processor stall and a reset bit that holds the system in reset. Releasing the reset bit, and only releasing it, produces a single-cycle system reset pulse. While the reset bit is set, the block reports an in-reset status, which neighbouring watchpoint and breakpoint logic uses to suppress its evaluation.

The core reports each exception it takes as a one-hot type vector with a valid strobe. A per-type stop-enable mask selects which exceptions the debugger wants to catch. A caught exception is flagged back to the core as ignored in the same cycle. Its type is logged into a sticky stop-reason register, and the hold bit is set so the core freezes. An exception that is not caught clears the hold bit and leaves the log alone. A global debugger-disable input masks the stall output without altering the stored hold bit.

Top module: `dbg_freeze_ctrl`

## Requirements
- R1: A synchronous power-on reset (`rst` high) clears the hold bit, the reset bit, the stop-reason register and the reset pulse. After it, `cpu_stall`, `in_reset`, `sys_reset_pulse` and `stop_reason` are all 0.
- R2: A cycle with `ctl_wr_en` high loads `ctl_wr_reset` into the reset bit and `ctl_wr_hold` into the hold bit together. The new values are seen on `in_reset` and (unless disabled) `cpu_stall` from the next cycle on.
- R3: `sys_reset_pulse` is high for exactly one cycle, the cycle after a control write that changes the reset bit from 1 to 0. Writes that keep the bit at 1, or that write 0 over 0, produce no pulse.
- R4: `cpu_stall` equals the hold bit while `dbg_off` is low, and is 0 in the same cycle whenever `dbg_off` is high. The hold bit keeps its value, so `cpu_stall` returns when `dbg_off` drops.
- R5: When `exc_valid` is high and the stop-enable bit of the reported type is set, `exc_ignore` is high in that same cycle. From the next cycle on, the matching `stop_reason` bit is 1 and the hold bit is 1. With `exc_valid` low, nothing happens and `exc_ignore` is 0.
- R6: When `exc_valid` is high and the stop-enable bit of the reported type is clear, `exc_ignore` is 0, `stop_reason` is unchanged and the hold bit is cleared. Stop-enable bits of other types have no effect.
- R7: `stop_reason` bits are sticky. They change only when a caught exception sets a bit, or when `why_wr_en` loads `why_wr_data`. A load in the same cycle as a caught exception keeps that exception's bit set.
- R8: Exception type bit positions, shared by `exc_type`, `exc_stop_mask`, `stop_reason` and `why_wr_data`, are: 0 external interrupt, 1 tick timer, 2 system call, 3 trap, 4 illegal instruction, 5 alignment, 6 range, 7 bus error, 8 data page fault, 9 instruction page fault, 10 data TLB miss, 11 instruction TLB miss, 12 reset.
- R9: If a control write and a valid exception happen in the same cycle, the written `ctl_wr_hold` value decides the hold bit. The exception still sets its reason bit if caught.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_reset | input | 1 | Reset bit value to write |
| ctl_wr_hold | input | 1 | Hold (stall) bit value to write |
| why_wr_en | input | 1 | Stop-reason register write strobe |
| why_wr_data | input | 13 | Stop-reason register write value |
| exc_valid | input | 1 | Exception report strobe |
| exc_type | input | 13 | One-hot exception type |
| exc_stop_mask | input | 13 | Per-type stop-enable bits |
| dbg_off | input | 1 | Global debugger disable, masks the stall output |
| cpu_stall | output | 1 | Processor stall request |
| in_reset | output | 1 | Reset bit status; suppresses watchpoint and breakpoint evaluation |
| sys_reset_pulse | output | 1 | One-cycle system reset pulse |
| stop_reason | output | 13 | Sticky record of caught exception types |
| exc_ignore | output | 1 | Current exception is caught for the debugger |

## Verification
`exc_ignore` and the `dbg_off` masking of `cpu_stall` are combinational, so they are due in the cycle of the stimulus. The bench checks them shortly after driving inputs at the falling edge. Register effects arrive one rising edge later: `in_reset`, the hold bit seen on `cpu_stall`, `stop_reason` and `sys_reset_pulse`. These are checked at the next falling edge, and the pulse is checked again one cycle after that to confirm it has dropped. A sweep over all thirteen exception types, with their own enable bit both clear and set, compares against a bench model of the reason register and the hold bit.

// File: rtl/dbg_freeze_pkg.sv
package dbg_freeze_pkg;

    localparam int EXC_N = 13;

    typedef logic [EXC_N-1:0] exc_vec_t;

    // Exception bit positions
    typedef enum int {
        EXC_EXT_INT   = 0,
        EXC_TICK      = 1,
        EXC_SYSCALL   = 2,
        EXC_TRAP      = 3,
        EXC_ILLEGAL   = 4,
        EXC_ALIGN     = 5,
        EXC_RANGE     = 6,
        EXC_BUS_ERR   = 7,
        EXC_DPAGE     = 8,
        EXC_IPAGE     = 9,
        EXC_DTLB_MISS = 10,
        EXC_ITLB_MISS = 11,
        EXC_RESET     = 12
    } exc_pos_e;

    typedef struct packed {
        logic reset_bit;
        logic hold_bit;
    } ctl_reg_t;

    function automatic exc_vec_t caught_types(input logic vld, input exc_vec_t typ,
                                              input exc_vec_t mask);
        return vld ? (typ & mask) : '0;
    endfunction

endpackage

// File: rtl/dfc_exc_filter.sv
module dfc_exc_filter
    import dbg_freeze_pkg::*;
(
    input  logic     exc_valid,
    input  exc_vec_t exc_type,
    input  exc_vec_t exc_stop_mask,
    output exc_vec_t hit_vec,
    output logic     caught
);
    always_comb begin
        hit_vec = caught_types(exc_valid, exc_type, exc_stop_mask);
        caught  = |hit_vec;
    end
endmodule

// File: rtl/dfc_ctl_reg.sv
module dfc_ctl_reg
    import dbg_freeze_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  ctl_reg_t wr_val,
    input  logic     exc_valid,
    input  logic     caught,
    output ctl_reg_t ctl_q,
    output logic     rel_pulse
);
    ctl_reg_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en)
            ctl_d = wr_val;
        else if (exc_valid)
            ctl_d.hold_bit = caught;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            rel_pulse <= 1'b0;
        end else begin
            ctl_q     <= ctl_d;
            rel_pulse <= ctl_q.reset_bit & ~ctl_d.reset_bit;
        end
    end
endmodule

// File: rtl/dfc_reason_log.sv
module dfc_reason_log
    import dbg_freeze_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  exc_vec_t wr_data,
    input  exc_vec_t hit_vec,
    output exc_vec_t reason_q
);
    always_ff @(posedge clk) begin
        if (rst)
            reason_q <= '0;
        else if (wr_en)
            reason_q <= wr_data | hit_vec;
        else
            reason_q <= reason_q | hit_vec;
    end
endmodule

// File: rtl/dbg_freeze_ctrl.sv
module dbg_freeze_ctrl
    import dbg_freeze_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr_en,
    input  logic             ctl_wr_reset,
    input  logic             ctl_wr_hold,
    input  logic             why_wr_en,
    input  logic [EXC_N-1:0] why_wr_data,
    input  logic             exc_valid,
    input  logic [EXC_N-1:0] exc_type,
    input  logic [EXC_N-1:0] exc_stop_mask,
    input  logic             dbg_off,
    output logic             cpu_stall,
    output logic             in_reset,
    output logic             sys_reset_pulse,
    output logic [EXC_N-1:0] stop_reason,
    output logic             exc_ignore
);
    exc_vec_t hit_vec;
    logic     caught;
    ctl_reg_t ctl_q;
    ctl_reg_t wr_val;

    assign wr_val = '{reset_bit: ctl_wr_reset, hold_bit: ctl_wr_hold};

    dfc_exc_filter u_filter (
        .exc_valid    (exc_valid),
        .exc_type     (exc_type),
        .exc_stop_mask(exc_stop_mask),
        .hit_vec      (hit_vec),
        .caught       (caught)
    );

    dfc_ctl_reg u_ctl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctl_wr_en),
        .wr_val   (wr_val),
        .exc_valid(exc_valid),
        .caught   (caught),
        .ctl_q    (ctl_q),
        .rel_pulse(sys_reset_pulse)
    );

    dfc_reason_log u_log (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (why_wr_en),
        .wr_data (why_wr_data),
        .hit_vec (hit_vec),
        .reason_q(stop_reason)
    );

    assign cpu_stall  = ctl_q.hold_bit & ~dbg_off;
    assign in_reset   = ctl_q.reset_bit;
    assign exc_ignore = caught;
endmodule

// File: rtl/dbg_freeze_chk.sv
module dbg_freeze_chk
    import dbg_freeze_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     ctl_wr_en,
    input logic     why_wr_en,
    input logic     exc_valid,
    input logic     dbg_off,
    input logic     cpu_stall,
    input logic     in_reset,
    input logic     sys_reset_pulse,
    input exc_vec_t stop_reason,
    input logic     exc_ignore
);
    // R3: pulse only where the reset bit has just dropped
    assert_pulse_on_release_R3: assert property (@(posedge clk) disable iff (rst)
        sys_reset_pulse |-> ($past(in_reset) && !in_reset));

    // R3: pulse lasts a single cycle
    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
        sys_reset_pulse |=> !sys_reset_pulse);

    // R4: debugger disable masks the stall
    assert_off_masks_stall_R4: assert property (@(posedge clk) disable iff (rst)
        dbg_off |-> !cpu_stall);

    // R5: caught exception stalls the core next cycle
    assert_caught_stalls_R5: assert property (@(posedge clk) disable iff (rst)
        (exc_ignore && !ctl_wr_en) |=> (cpu_stall || dbg_off));

    // R5: caught exception leaves a reason bit behind
    assert_caught_logged_R5: assert property (@(posedge clk) disable iff (rst)
        exc_ignore |=> (stop_reason != '0));

    // R5: no flag without a valid exception
    assert_ignore_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
        exc_ignore |-> exc_valid);

    // R6: uncaught exception releases the stall
    assert_uncaught_releases_R6: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && !exc_ignore && !ctl_wr_en) |=> !cpu_stall);

    // R7: reason bits never drop without a write
    assert_reason_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !why_wr_en |=> ((stop_reason & $past(stop_reason)) == $past(stop_reason)));
endmodule

bind dbg_freeze_ctrl dbg_freeze_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .ctl_wr_en      (ctl_wr_en),
    .why_wr_en      (why_wr_en),
    .exc_valid      (exc_valid),
    .dbg_off        (dbg_off),
    .cpu_stall      (cpu_stall),
    .in_reset       (in_reset),
    .sys_reset_pulse(sys_reset_pulse),
    .stop_reason    (stop_reason),
    .exc_ignore     (exc_ignore)
);

// File: tb/dbg_freeze_ctrl_test.sv
`timescale 1ns/1ps
module dbg_freeze_ctrl_test;
    localparam int N = 13;
    localparam logic [N-1:0] ALL = {N{1'b1}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_wr_en = 0, ctl_wr_reset = 0, ctl_wr_hold = 0;
    logic why_wr_en = 0;
    logic [N-1:0] why_wr_data = '0;
    logic exc_valid = 0;
    logic [N-1:0] exc_type = '0, exc_stop_mask = '0;
    logic dbg_off = 0;
    logic cpu_stall, in_reset, sys_reset_pulse, exc_ignore;
    logic [N-1:0] stop_reason;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] exp_reason;

    always #2.5 clk = ~clk;

    dbg_freeze_ctrl uut (
        .clk(clk), .rst(rst),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_reset(ctl_wr_reset), .ctl_wr_hold(ctl_wr_hold),
        .why_wr_en(why_wr_en), .why_wr_data(why_wr_data),
        .exc_valid(exc_valid), .exc_type(exc_type), .exc_stop_mask(exc_stop_mask),
        .dbg_off(dbg_off),
        .cpu_stall(cpu_stall), .in_reset(in_reset), .sys_reset_pulse(sys_reset_pulse),
        .stop_reason(stop_reason), .exc_ignore(exc_ignore)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ctl_wr_en = 0; why_wr_en = 0; exc_valid = 0; exc_type = '0;
    endtask

    // Advance to next falling edge, one rising edge applied
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic r, input logic h);
        ctl_wr_en = 1; ctl_wr_reset = r; ctl_wr_hold = h;
        tick();
        idle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        exp_reason = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 stall", cpu_stall, 0);
        chk("R1 in_reset", in_reset, 0);
        chk("R1 pulse", sys_reset_pulse, 0);
        chk("R1 reason", stop_reason, 0);

        // R2: both bits written together
        wr_ctl(1, 1);
        chk("R2 in_reset", in_reset, 1);
        chk("R2 stall", cpu_stall, 1);
        chk("R3 no pulse on set", sys_reset_pulse, 0);
        wr_ctl(1, 0);
        chk("R2 stall cleared", cpu_stall, 0);
        chk("R3 no pulse while held", sys_reset_pulse, 0);
        chk("R2 still in reset", in_reset, 1);
        wr_ctl(0, 0);
        chk("R3 pulse on release", sys_reset_pulse, 1);
        chk("R3 in_reset low", in_reset, 0);
        tick();
        chk("R3 pulse one cycle", sys_reset_pulse, 0);
        wr_ctl(0, 0);
        chk("R3 no pulse 0 over 0", sys_reset_pulse, 0);

        // R4: disable masks the stall, bit kept
        wr_ctl(0, 1);
        dbg_off = 1;
        #1 chk("R4 masked", cpu_stall, 0);
        tick();
        chk("R4 still masked", cpu_stall, 0);
        dbg_off = 0;
        #1 chk("R4 restored", cpu_stall, 1);

        // Sweep, enable clear (R6) then set (R5), every type (R8)
        for (int en = 0; en < 2; en++) begin
            for (int k = 0; k < N; k++) begin
                wr_ctl(0, en == 0);
                exc_valid = 1;
                exc_type = N'(1) << k;
                exc_stop_mask = (en != 0) ? ALL : (ALL & ~(N'(1) << k));
                #1 chk(en ? "R5 ignore" : "R6 ignore", exc_ignore, en);
                if (en != 0) exp_reason[k] = 1'b1;
                tick();
                idle();
                chk(en ? "R8 R5 reason" : "R6 reason", stop_reason, exp_reason);
                chk(en ? "R5 stall" : "R6 stall", cpu_stall, en);
            end
        end

        // R5: mask without valid does nothing
        wr_ctl(0, 0);
        exc_type = N'(1) << 4; exc_stop_mask = ALL;
        #1 chk("R5 no valid no ignore", exc_ignore, 0);
        tick();
        chk("R5 no valid no stall", cpu_stall, 0);
        idle();

        // R7: clear by write, write with concurrent catch
        why_wr_en = 1; why_wr_data = '0;
        tick(); idle();
        chk("R7 cleared", stop_reason, 0);
        tick();
        chk("R7 stays clear", stop_reason, 0);
        why_wr_en = 1; why_wr_data = N'(1) << 0;
        exc_valid = 1; exc_type = N'(1) << 12; exc_stop_mask = ALL;
        tick(); idle();
        chk("R7 write plus catch", stop_reason, (N'(1) << 12) | N'(1));

        // R9: control write beats exception on hold bit
        why_wr_en = 1; why_wr_data = '0; tick(); idle();
        ctl_wr_en = 1; ctl_wr_reset = 0; ctl_wr_hold = 0;
        exc_valid = 1; exc_type = N'(1) << 7; exc_stop_mask = ALL;
        tick(); idle();
        chk("R9 write wins stall", cpu_stall, 0);
        chk("R9 reason still set", stop_reason, N'(1) << 7);
        ctl_wr_en = 1; ctl_wr_hold = 1;
        exc_valid = 1; exc_type = N'(1) << 3; exc_stop_mask = '0;
        tick(); idle();
        chk("R9 write wins over uncaught", cpu_stall, 1);

        // R4 with caught exception: logged, stall masked
        dbg_off = 1;
        exc_valid = 1; exc_type = N'(1) << 9; exc_stop_mask = ALL;
        tick(); idle();
        chk("R4 masked after catch", cpu_stall, 0);
        chk("R4 reason logged", stop_reason, (N'(1) << 7) | (N'(1) << 9));
        dbg_off = 0;
        #1 chk("R4 stall after release", cpu_stall, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule